// File: doc/BRIEF.md
# Oscillator Fail Flag and Output Level Control

This block keeps the sticky oscillator-fail flag of a timekeeping core, the stop bit that halts the oscillator, and the control bit that sets an open-drain output pin. The analog oscillator is not modelled. It is seen only as a heartbeat input whose rising edges show that it is running. A loss timer on the system clock reports a stop when the heartbeat falls silent. A run qualifier counts heartbeat edges and decides when the oscillator has run long enough for software to clear the flag.

Software writes through a plain single-cycle write port: an enable, a register address and a data byte. Only bit 7 of each addressed register has meaning. The fail flag is raised by reset, by a heartbeat timeout and by the stop bit. It then holds at 1. A write of 0 lowers it only after an unbroken run of RUN_SECONDS × EDGES_PER_SECOND heartbeat edges. A write of 0 that arrives earlier is dropped.

Top module: `osc_fail_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fail_flag` is 1, `stop_bit` is 0, `out_level` is 1 and `clear_ready` is 0.
- R2: A write to address 0 loads `stop_bit` from data bit 7. A write to address 7 loads `out_level` from data bit 7. A write to address 1 acts on the fail flag through data bit 7. Writes to any other address, and data bits 6..0, change none of the outputs.
- R3: `out_pull_low` is 1 exactly when `out_level` is 0, so a 0 pulls the pin low and a 1 releases it.
- R4: When no heartbeat rising edge arrives for TIMEOUT_CYC system clock cycles, `osc_running` drops to 0 and `fail_flag` is 1 from the following cycle on. The next heartbeat edge restores `osc_running`.
- R5: While `stop_bit` is 1, `fail_flag` is 1 from the following cycle on, and `clear_ready` is 0.
- R6: `clear_ready` rises once RUN_SECONDS × EDGES_PER_SECOND heartbeat rising edges have been counted. Counting starts from the edge that ends a timeout, or from the release of the stop bit. A timeout or a stop bit of 1 resets the count, and edges during a stop are not counted.
- R7: A write of 0 to bit 7 at address 1 clears `fail_flag` only when `clear_ready` is 1 and no set cause is active. Otherwise the write is ignored and the flag stays 1.
- R8: A write of 1 to bit 7 at address 1 sets `fail_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| hb_in | input | 1 | Oscillator heartbeat, asynchronous to clk |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address (0 stop, 1 flag, 7 control) |
| wr_data | input | DATA_W | Write data; only the top bit is used |
| fail_flag | output | 1 | Sticky oscillator-fail flag |
| stop_bit | output | 1 | Oscillator stop request |
| out_level | output | 1 | Stored output pin level |
| out_pull_low | output | 1 | Open-drain pull-down enable for the pin |
| osc_running | output | 1 | Heartbeat seen within the timeout window |
| clear_ready | output | 1 | Run qualification complete; a clear is accepted |

## Verification
The bench uses TIMEOUT_CYC = 20, EDGES_PER_SECOND = 4 and RUN_SECONDS = 4. With these values a timeout takes a few dozen cycles and the clear threshold is 16 edges. The edge counts on both sides of that threshold (15, 16 and random runs from 8 to 24) can therefore be driven directly. Heartbeat half-periods are random between 1 and 8 cycles. This keeps every gap below the timeout, while deliberate silences of 30 cycles give a clean loss event.

// File: rtl/osc_fail_pkg.sv
package osc_fail_pkg;
  // register addresses decoded by the write port
  localparam int ADDR_STOP_REG = 0;
  localparam int ADDR_FLAG_REG = 1;
  localparam int ADDR_CTRL_REG = 7;

  // power-up values
  localparam logic RST_FLAG = 1'b1;
  localparam logic RST_STOP = 1'b0;
  localparam logic RST_OUT  = 1'b1;
endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_in,
  output logic hb_rise
);
  localparam int W = STAGES + 1;

  logic [W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[W-2:0], hb_in};
  end

  // newest synchronised sample high, previous one low
  assign hb_rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/osc_loss_timer.sv
module osc_loss_timer #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_rise,
  output logic osc_dead
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_cnt <= '0;
    else if (hb_rise)          idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign osc_dead = (idle_cnt == LIMIT);
endmodule

// File: rtl/run_qualifier.sv
module run_qualifier #(
  parameter int RUN_EDGES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_rise,
  input  logic osc_dead,
  input  logic stop_bit,
  output logic clear_ready
);
  localparam int RW = $clog2(RUN_EDGES + 1);
  localparam logic [RW-1:0] FULL = RW'(RUN_EDGES);

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (stop_bit) begin
      run_cnt <= '0;
    end else if (hb_rise) begin
      // the edge ending a timeout starts a fresh run of one
      if (osc_dead)             run_cnt <= RW'(1);
      else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
    end else if (osc_dead) begin
      run_cnt <= '0;
    end
  end

  assign clear_ready = (run_cnt == FULL);
endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
  import osc_fail_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic              osc_dead,
  input  logic              clear_ready,
  output logic              fail_flag,
  output logic              stop_bit,
  output logic              out_level
);
  logic wr_stop, wr_flag, wr_ctrl;

  assign wr_stop = wr_en && (wr_addr == ADDR_W'(ADDR_STOP_REG));
  assign wr_flag = wr_en && (wr_addr == ADDR_W'(ADDR_FLAG_REG));
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL_REG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_bit  <= RST_STOP;
      out_level <= RST_OUT;
    end else begin
      if (wr_stop) stop_bit  <= wr_bit;
      if (wr_ctrl) out_level <= wr_bit;
    end
  end

  // set causes outrank a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fail_flag <= RST_FLAG;
    else if (osc_dead || stop_bit) fail_flag <= 1'b1;
    else if (wr_flag) begin
      if (wr_bit)           fail_flag <= 1'b1;
      else if (clear_ready) fail_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/osc_fail_monitor.sv
module osc_fail_monitor
  import osc_fail_pkg::*;
#(
  parameter int ADDR_W           = 3,
  parameter int DATA_W           = 8,
  parameter int SYNC_STAGES      = 2,
  parameter int TIMEOUT_CYC      = 4096,
  parameter int EDGES_PER_SECOND = 32768,
  parameter int RUN_SECONDS      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fail_flag,
  output logic              stop_bit,
  output logic              out_level,
  output logic              out_pull_low,
  output logic              osc_running,
  output logic              clear_ready
);
  localparam int RUN_EDGES = RUN_SECONDS * EDGES_PER_SECOND;

  logic hb_rise, osc_dead;
  logic unused_low_bits;

  assign unused_low_bits = ^wr_data[DATA_W-2:0];

  hb_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .hb_rise(hb_rise)
  );

  osc_loss_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) loss_i (
    .clk(clk), .rst_n(rst_n), .hb_rise(hb_rise), .osc_dead(osc_dead)
  );

  run_qualifier #(.RUN_EDGES(RUN_EDGES)) run_i (
    .clk(clk), .rst_n(rst_n), .hb_rise(hb_rise), .osc_dead(osc_dead),
    .stop_bit(stop_bit), .clear_ready(clear_ready)
  );

  osc_ctrl_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bit(wr_data[DATA_W-1]), .osc_dead(osc_dead),
    .clear_ready(clear_ready), .fail_flag(fail_flag),
    .stop_bit(stop_bit), .out_level(out_level)
  );

  assign osc_running  = ~osc_dead;
  assign out_pull_low = ~out_level;
endmodule

// File: rtl/osc_fail_monitor_chk.sv
module osc_fail_monitor_chk
  import osc_fail_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              fail_flag,
  input logic              stop_bit,
  input logic              out_level,
  input logic              osc_running,
  input logic              clear_ready
);
  a_r1_reset_values: assert property (@(posedge clk)
    $rose(rst_n) |-> (fail_flag && !stop_bit && out_level && !clear_ready));

  a_r2_out_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_level) |-> $past(wr_en && wr_addr == ADDR_W'(ADDR_CTRL_REG)));

  a_r4_loss_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_running |=> fail_flag);

  a_r5_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |=> (fail_flag && !clear_ready));

  a_r6_ready_drops_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_ready) |-> $past(stop_bit || !osc_running));

  a_r7_clear_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> $past(clear_ready && wr_en &&
                               wr_addr == ADDR_W'(ADDR_FLAG_REG) && !wr_data[DATA_W-1]));
endmodule

bind osc_fail_monitor osc_fail_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fail_flag(fail_flag), .stop_bit(stop_bit), .out_level(out_level),
  .osc_running(osc_running), .clear_ready(clear_ready)
);

// File: tb/osc_fail_monitor_tb_top.sv
`timescale 1ns/1ps
module osc_fail_monitor_tb_top;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int TIMEOUT_CYC = 20;
  localparam int EDGES_PER_SECOND = 4;
  localparam int RUN_SECONDS = 4;
  localparam int RUN_EDGES = RUN_SECONDS * EDGES_PER_SECOND;

  logic clk = 1'b0;
  logic rst_n, hb_in, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic fail_flag, stop_bit, out_level, out_pull_low, osc_running, clear_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  osc_fail_monitor #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2),
    .TIMEOUT_CYC(TIMEOUT_CYC), .EDGES_PER_SECOND(EDGES_PER_SECOND),
    .RUN_SECONDS(RUN_SECONDS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .fail_flag(fail_flag),
    .stop_bit(stop_bit), .out_level(out_level), .out_pull_low(out_pull_low),
    .osc_running(osc_running), .clear_ready(clear_ready)
  );

  function automatic logic exp_ready(input int edges);
    return edges >= RUN_EDGES;
  endfunction

  function automatic logic exp_flag_after_clear(input int edges);
    return !(edges >= RUN_EDGES);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_edges(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      hb_in = 1'b1; wait_cyc(half);
      hb_in = 1'b0; wait_cyc(half);
    end
    wait_cyc(5);
  endtask

  task automatic kill_osc();
    hb_in = 1'b0;
    wait_cyc(TIMEOUT_CYC + 10);
  endtask

  initial begin
    rst_n = 1'b0; hb_in = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    void'($urandom(32'h5eed_0042));
    wait_cyc(3);
    check("R1 flag in reset", fail_flag, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag", fail_flag, 1'b1);
    check("R1 stop", stop_bit, 1'b0);
    check("R1 out", out_level, 1'b1);
    check("R1 ready", clear_ready, 1'b0);
    check("R3 released at reset", out_pull_low, 1'b0);

    // output pin control
    write_reg(7, 8'h00);
    check("R2 out write 0", out_level, 1'b0);
    check("R3 pull low", out_pull_low, 1'b1);
    write_reg(7, 8'h7F);
    check("R2 low bits ignored", out_level, 1'b0);
    write_reg(7, 8'h80);
    check("R2 out write 1", out_level, 1'b1);
    check("R3 released", out_pull_low, 1'b0);
    write_reg(3, 8'h00);
    check("R2 other addr out", out_level, 1'b1);
    check("R2 other addr stop", stop_bit, 1'b0);
    check("R2 other addr flag", fail_flag, 1'b1);

    // heartbeat loss
    kill_osc();
    check("R4 osc stopped", osc_running, 1'b0);
    check("R4 flag", fail_flag, 1'b1);

    // one edge short of qualification
    pulse_edges(RUN_EDGES - 1, 2);
    check("R4 osc restored", osc_running, 1'b1);
    check("R6 not ready at 15", clear_ready, 1'b0);
    write_reg(1, 8'h00);
    check("R7 early clear ignored", fail_flag, 1'b1);
    pulse_edges(1, 2);
    check("R6 ready at 16", clear_ready, 1'b1);
    write_reg(1, 8'h00);
    check("R7 clear accepted", fail_flag, 1'b0);
    write_reg(1, 8'h80);
    check("R8 write 1 sets", fail_flag, 1'b1);
    write_reg(1, 8'h00);
    check("R7 clear again", fail_flag, 1'b0);

    // stop bit
    write_reg(0, 8'h80);
    wait_cyc(1);
    check("R2 stop written", stop_bit, 1'b1);
    check("R5 flag set by stop", fail_flag, 1'b1);
    check("R5 ready dropped", clear_ready, 1'b0);
    pulse_edges(RUN_EDGES + 4, 2);
    check("R6 edges ignored while stopped", clear_ready, 1'b0);
    write_reg(1, 8'h00);
    check("R7 clear ignored while stopped", fail_flag, 1'b1);
    write_reg(0, 8'h00);
    check("R2 stop released", stop_bit, 1'b0);
    pulse_edges(RUN_EDGES, 3);
    check("R6 ready after release", clear_ready, 1'b1);
    write_reg(1, 8'h00);
    check("R7 clear after release", fail_flag, 1'b0);

    kill_osc();
    check("R4 loss after clear", fail_flag, 1'b1);
    check("R6 ready reset by loss", clear_ready, 1'b0);

    // random runs around the threshold
    for (int t = 0; t < 16; t++) begin
      int k = $urandom_range(24, 8);
      int half = $urandom_range(8, 1);
      if ($urandom_range(1, 0) == 1) kill_osc();
      else begin
        write_reg(0, 8'h80); wait_cyc(2);
        write_reg(0, 8'h00); wait_cyc(2);
      end
      check("R4 R5 flag set before run", fail_flag, 1'b1);
      pulse_edges(k, half);
      check("R6 random ready", clear_ready, exp_ready(k));
      write_reg(1, 8'h00);
      check("R7 random clear", fail_flag, exp_flag_after_clear(k));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..R8 run incomplete): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule